// File: doc/BRIEF.md
# NAND Flash Host Interface

This block sits between a simple register bus and an 8-bit raw NAND flash device. Software writes command, address and data bytes into registers; each write becomes an entry in a small shared write buffer, and a bus sequencer plays the entries onto the flash pins in order. Command entries drive the command latch line and address entries drive the address latch line. Data entries pulse the write strobe, and each strobe lasts a programmable number of clocks.

Reading a byte takes two steps. Software writes any value to the read-request register. The sequencer pulses the read strobe and captures the flash data bus at the end of the pulse. It then places the byte in the read-data register and raises a sticky read-ready flag. A page-read engine can issue a whole page of such reads, one after the other. A page-write counter tracks a whole page of data bytes and raises a done flag when the page is complete. The ready/busy pin is synchronized; its level appears in the status register and its rising edge sets an event flag.

Top module: `nand_host_ctrl`

## Requirements
- R1: After reset the status register reads 0x11 (empty bit 4 and ready bit 0 set), the interrupt register reads 0, `irq_o` is low and the chip-enable, write-strobe and read-strobe pins are all high.
- R2: Register offsets: 0 control, 1 status, 2 interrupt, 3 command, 4 address, 5 write data, 6 read request, 7 read data, 8 page control. A write to offset 3 makes one write-strobe cycle with the command latch high and the address latch low. A write to offset 4 makes one with the address latch high. A write to offset 5 makes one with both latches low. In every case the written byte is on `nf_dq_o` with `nf_dq_oe` high.
- R3: Control bits [3:0] hold the write-strobe delay and bits [7:4] hold the read-strobe delay. A write strobe stays low for write delay + 1 clocks and a read strobe for read delay + 1 clocks. Both strobes are high for at least one clock between two bus cycles.
- R4: The write buffer holds FIFO_DEPTH entries and replays them in push order. Status bit 1 is set while it is full, and status bit 4 is set while it is empty.
- R5: A push to offsets 3 to 6 while the buffer is full is dropped (it never reaches the bus) and sets interrupt bit 1.
- R6: A write of any value to offset 6 makes one read-strobe cycle. The value on `nf_dq_i` at the last clock of the strobe appears at offset 7, and interrupt bit 3 sets.
- R7: Writing 1 to an interrupt bit clears it. Writing 0 leaves it unchanged.
- R8: Status bit 0 follows `nf_rb` through a synchronizer. A rising edge of the synchronized level sets interrupt bit 0.
- R9: Interrupt bit 2 sets when the write buffer goes from non-empty to empty.
- R10: Writing page control with bit 1 set, while no page operation is pending, sets status bit 2. Status bit 2 clears after one page of data-byte cycles, and interrupt bit 4 then sets. Control bit 9 selects the page length: LARGE_PAGE when 1, SMALL_PAGE when 0.
- R11: Writing page control with bit 0 set, while no page operation is pending, sets status bit 3. The block then issues one read cycle at a time, each only while the buffer is empty and interrupt bit 3 is clear. Each byte goes to offset 7 and sets interrupt bit 3. Status bit 3 clears when the last byte of the page is captured.
- R12: Control bits 8 (bus width) and 9 (page size) and both delay fields read back as written. The bus-width bit does not change the 8-bit bus cycles.
- R13: `irq_o` is high exactly when any interrupt bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | OR of all interrupt bits |
| nf_ce_n | output | 1 | Flash chip enable, low during a bus cycle |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_i | input | 8 | Flash data in |
| nf_rb | input | 1 | Flash ready (high) / busy (low) |

## Verification
The bench builds the block with a 3-bit delay field, a 4-entry buffer and page lengths of 4 and 8 bytes. With a 3-bit delay, the longest strobe of 8 clocks keeps the sequencer busy long enough for six back-to-back pushes to fill the buffer and overflow it. The short pages let the page-read and page-write counters reach their end and switch the page-size select within a few dozen cycles. Random batches of mixed command, address and data bytes, each with its own random write delay, are checked against a strobe log kept from the pins.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   typedef enum logic [1:0] {
      K_CMD   = 2'd0,
      K_ADDR  = 2'd1,
      K_DATA  = 2'd2,
      K_RDREQ = 2'd3
   } nfc_kind_e;

   typedef struct packed {
      nfc_kind_e  kind;
      logic [7:0] val;
   } nfc_ent_t;

   localparam logic [3:0] OFS_CTRL  = 4'd0;
   localparam logic [3:0] OFS_STAT  = 4'd1;
   localparam logic [3:0] OFS_IRQ   = 4'd2;
   localparam logic [3:0] OFS_CMD   = 4'd3;
   localparam logic [3:0] OFS_ADDR  = 4'd4;
   localparam logic [3:0] OFS_WDAT  = 4'd5;
   localparam logic [3:0] OFS_RREQ  = 4'd6;
   localparam logic [3:0] OFS_RDAT  = 4'd7;
   localparam logic [3:0] OFS_PGCTL = 4'd8;

   localparam int IRQ_RB   = 0;
   localparam int IRQ_OVF  = 1;
   localparam int IRQ_EDGE = 2;
   localparam int IRQ_RRDY = 3;
   localparam int IRQ_PWD  = 4;
endpackage

// File: rtl/nfc_fifo.sv
module nfc_fifo #(
   parameter int WIDTH = 10,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("nfc_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW:0]      wp, rp;

   assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
   assign empty = (wp == rp);
   assign dout  = mem[rp[PW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push && !full) begin
            mem[wp[PW-1:0]] <= din;
            wp <= wp + 1'b1;
         end
         if (pop && !empty) rp <= rp + 1'b1;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (wp == $past(wp))); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty) |=> (rp == $past(rp))); // R4
endmodule

// File: rtl/nfc_sync.sv
module nfc_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("nfc_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic s;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s <= RESET_VAL;
         else        s <= d;
      end
      assign q = s;
   end else begin : g_chain
      logic [STAGES-1:0] s;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) s <= {STAGES{RESET_VAL}};
         else        s <= {s[STAGES-2:0], d};
      end
      assign q = s[STAGES-1];
   end
endmodule

// File: rtl/nfc_bus_seq.sv
module nfc_bus_seq
   import nfc_pkg::*;
#(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  nfc_kind_e        start_kind,
   input  logic [7:0]       start_val,
   input  logic [DLY_W-1:0] wr_dly,
   input  logic [DLY_W-1:0] rd_dly,
   input  logic [7:0]       dq_i,
   output logic             idle,
   output logic             cap_valid,
   output logic [7:0]       cap_data,
   output logic             data_done,
   output logic             ce_n,
   output logic             cle,
   output logic             ale,
   output logic             we_n,
   output logic             re_n,
   output logic [7:0]       dq_o,
   output logic             dq_oe
);
   typedef enum logic [1:0] {S_IDLE, S_STRB, S_HOLD} seq_st_e;

   seq_st_e          st;
   nfc_kind_e        kind;
   logic [7:0]       val;
   logic [DLY_W-1:0] cnt;
   logic             strb, last, active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         kind <= K_CMD;
         val  <= '0;
         cnt  <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (start) begin
               st   <= S_STRB;
               kind <= start_kind;
               val  <= start_val;
               cnt  <= (start_kind == K_RDREQ) ? rd_dly : wr_dly;
            end
            S_STRB: begin
               if (cnt == '0) st <= S_HOLD;
               else           cnt <= cnt - 1'b1;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign strb      = (st == S_STRB);
   assign active    = (st != S_IDLE);
   assign last      = strb && (cnt == '0);
   assign idle      = !active;
   assign cap_valid = last && (kind == K_RDREQ);
   assign cap_data  = dq_i;
   assign data_done = last && (kind == K_DATA);
   assign ce_n      = !active;
   assign cle       = active && (kind == K_CMD);
   assign ale       = active && (kind == K_ADDR);
   assign we_n      = !(strb && (kind != K_RDREQ));
   assign re_n      = !(strb && (kind == K_RDREQ));
   assign dq_o      = val;
   assign dq_oe     = active && (kind != K_RDREQ);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!we_n && !re_n)); // R3
   AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale)); // R2
   AST_HOLD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(we_n) || $rose(re_n)) |=> (we_n && re_n)); // R3
   AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n || !re_n) |-> !ce_n); // R2
endmodule

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
   import nfc_pkg::*;
#(
   parameter int FIFO_DEPTH  = 4,
   parameter int DLY_W       = 4,
   parameter int SMALL_PAGE  = 256,
   parameter int LARGE_PAGE  = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [3:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        irq_o,
   output logic        nf_ce_n,
   output logic        nf_cle,
   output logic        nf_ale,
   output logic        nf_we_n,
   output logic        nf_re_n,
   output logic [7:0]  nf_dq_o,
   output logic        nf_dq_oe,
   input  logic [7:0]  nf_dq_i,
   input  logic        nf_rb
);
   localparam int ENT_W = $bits(nfc_ent_t);
   localparam int PG_W  = $clog2(LARGE_PAGE + 1);

   if (DLY_W < 1 || DLY_W > 4) begin : g_bad_dly
      $error("nand_host_ctrl: DLY_W must be 1 to 4");
   end
   if (SMALL_PAGE < 1 || SMALL_PAGE > LARGE_PAGE) begin : g_bad_page
      $error("nand_host_ctrl: need 1 <= SMALL_PAGE <= LARGE_PAGE");
   end

   logic [DLY_W-1:0] wr_dly, rd_dly;
   logic             width_q, page_q;
   logic [4:0]       irq_q, irq_set, irq_clr;
   logic [7:0]       rdat_q;
   logic             rd_pend, wr_pend;
   logic [PG_W-1:0]  pg_left, pg_len;
   logic             rb_s, rb_q, empty_q;

   logic     push_req, fifo_full, fifo_empty, pop;
   nfc_ent_t push_ent, head_ent;
   logic     seq_idle, seq_start, cap_valid, data_done;
   logic [7:0] cap_data;
   nfc_kind_e  seq_kind;
   logic       pg_issue, pg_last;

   // host pushes and the entry they create
   assign push_req = reg_wr && (reg_addr >= OFS_CMD) && (reg_addr <= OFS_RREQ);
   always_comb begin
      unique case (reg_addr)
         OFS_CMD:  push_ent.kind = K_CMD;
         OFS_ADDR: push_ent.kind = K_ADDR;
         OFS_WDAT: push_ent.kind = K_DATA;
         default:  push_ent.kind = K_RDREQ;
      endcase
      push_ent.val = reg_wdata[7:0];
   end

   nfc_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk, .rst_n, .push(push_req), .din(push_ent), .pop,
      .dout(head_ent), .full(fifo_full), .empty(fifo_empty)
   );

   // buffer entries first, page-read engine only on an idle buffer
   assign pop       = seq_idle && !fifo_empty;
   assign pg_issue  = seq_idle && fifo_empty && rd_pend && !irq_q[IRQ_RRDY];
   assign seq_start = pop || pg_issue;
   assign seq_kind  = pop ? head_ent.kind : K_RDREQ;

   nfc_bus_seq #(.DLY_W(DLY_W)) u_seq (
      .clk, .rst_n, .start(seq_start), .start_kind(seq_kind),
      .start_val(pop ? head_ent.val : 8'h00), .wr_dly, .rd_dly,
      .dq_i(nf_dq_i), .idle(seq_idle), .cap_valid, .cap_data, .data_done,
      .ce_n(nf_ce_n), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n),
      .re_n(nf_re_n), .dq_o(nf_dq_o), .dq_oe(nf_dq_oe)
   );

   nfc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rb_sync (
      .clk, .rst_n, .d(nf_rb), .q(rb_s)
   );

   assign pg_len  = page_q ? PG_W'(LARGE_PAGE) : PG_W'(SMALL_PAGE);
   assign pg_last = (pg_left == PG_W'(1));

   always_comb begin
      irq_set           = '0;
      irq_set[IRQ_RB]   = rb_s && !rb_q;
      irq_set[IRQ_OVF]  = push_req && fifo_full;
      irq_set[IRQ_EDGE] = fifo_empty && !empty_q;
      irq_set[IRQ_RRDY] = cap_valid;
      irq_set[IRQ_PWD]  = data_done && wr_pend && pg_last;
      irq_clr = (reg_wr && reg_addr == OFS_IRQ) ? reg_wdata[4:0] : 5'd0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_dly  <= '0;
         rd_dly  <= '0;
         width_q <= 1'b0;
         page_q  <= 1'b1;
         irq_q   <= '0;
         rdat_q  <= '0;
         rd_pend <= 1'b0;
         wr_pend <= 1'b0;
         pg_left <= '0;
         rb_q    <= 1'b1;
         empty_q <= 1'b1;
      end else begin
         rb_q    <= rb_s;
         empty_q <= fifo_empty;
         irq_q   <= (irq_q & ~irq_clr) | irq_set;
         if (reg_wr && reg_addr == OFS_CTRL) begin
            wr_dly  <= reg_wdata[DLY_W-1:0];
            rd_dly  <= reg_wdata[4 +: DLY_W];
            width_q <= reg_wdata[8];
            page_q  <= reg_wdata[9];
         end
         if (cap_valid) rdat_q <= cap_data;
         if (reg_wr && reg_addr == OFS_PGCTL && !rd_pend && !wr_pend) begin
            if (reg_wdata[0]) begin
               rd_pend <= 1'b1;
               pg_left <= pg_len;
            end else if (reg_wdata[1]) begin
               wr_pend <= 1'b1;
               pg_left <= pg_len;
            end
         end else if ((cap_valid && rd_pend) || (data_done && wr_pend)) begin
            pg_left <= pg_left - 1'b1;
            if (pg_last) begin
               rd_pend <= 1'b0;
               wr_pend <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_CTRL: begin
            reg_rdata[DLY_W-1:0]  = wr_dly;
            reg_rdata[4 +: DLY_W] = rd_dly;
            reg_rdata[8]          = width_q;
            reg_rdata[9]          = page_q;
         end
         OFS_STAT: reg_rdata[4:0] = {fifo_empty, rd_pend, wr_pend, fifo_full, rb_s};
         OFS_IRQ:  reg_rdata[4:0] = irq_q;
         OFS_RDAT: reg_rdata[7:0] = rdat_q;
         default:  reg_rdata = '0;
      endcase
   end

   assign irq_o = |irq_q;

   AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |=> (irq_q[IRQ_RRDY] && rdat_q == $past(cap_data))); // R6
   AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && fifo_full) |=> irq_q[IRQ_OVF]); // R5
   AST_PAGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_pend && wr_pend)); // R10
   AST_PAGE_READ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_start && !pop) |-> (fifo_empty && !irq_q[IRQ_RRDY] && rd_pend)); // R11
   AST_RB_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rb_s) |=> irq_q[IRQ_RB]); // R8
endmodule

// File: tb/test_nand_host_ctrl.sv
module test_nand_host_ctrl;
   localparam int DLY_W = 3;
   localparam int SMALL = 4;
   localparam int LARGE = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic irq_o, nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic [7:0] nf_dq_o;
   logic [7:0] nf_dq_i = '0;
   logic nf_rb = 1'b1;

   always #5 clk = ~clk;

   nand_host_ctrl #(.FIFO_DEPTH(4), .DLY_W(DLY_W), .SMALL_PAGE(SMALL),
                    .LARGE_PAGE(LARGE), .SYNC_STAGES(2)) i_nand_host_ctrl (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata, .irq_o,
      .nf_ce_n, .nf_cle, .nf_ale, .nf_we_n, .nf_re_n, .nf_dq_o, .nf_dq_oe,
      .nf_dq_i, .nf_rb
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // strobe log taken from the pins
   int log_k [64];
   int log_d [64];
   int log_w [64];
   int n_log = 0;
   int wlen = 0, rlen = 0, gap = 0, gap_bad = 0, seen = 0;
   int wk = 0, wd = 0;

   int exp_k [64];
   int exp_d [64];
   int exp_w [64];
   int n_exp = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if ((!nf_we_n || !nf_re_n) && wlen == 0 && rlen == 0) begin
            if (seen != 0 && gap < 1) gap_bad++;
         end
         if (!nf_we_n) begin
            wlen++;
            wk = nf_cle ? 0 : (nf_ale ? 1 : 2);
            wd = nf_dq_o;
         end else if (wlen > 0) begin
            if (n_log < 64) begin
               log_k[n_log] = wk; log_d[n_log] = wd; log_w[n_log] = wlen; n_log++;
            end
            wlen = 0; gap = 0; seen = 1;
         end
         if (!nf_re_n) rlen++;
         else if (rlen > 0) begin
            if (n_log < 64) begin
               log_k[n_log] = 3; log_d[n_log] = 0; log_w[n_log] = rlen; n_log++;
            end
            rlen = 0; gap = 0; seen = 1;
         end
         if (nf_we_n && nf_re_n && wlen == 0 && rlen == 0) gap++;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int v);
      @(negedge clk);
      reg_addr = a;
      #1 v = int'(reg_rdata);
   endtask

   function automatic int strobe_w(input int k, input int wdl, input int rdl);
      return (k == 3) ? rdl + 1 : wdl + 1;
   endfunction

   function automatic int kind_ofs(input int k);
      return 3 + k;
   endfunction

   task automatic drain();
      int v;
      do begin
         rd(4'd1, v);
      end while (!(v[4] && nf_ce_n));
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_logs();
      n_log = 0; n_exp = 0;
   endtask

   task automatic expect_ent(input int k, input int d, input int w);
      exp_k[n_exp] = k; exp_d[n_exp] = d; exp_w[n_exp] = w; n_exp++;
   endtask

   task automatic compare_log(input string req);
      chk(n_log == n_exp, req, n_log, n_exp);
      for (int i = 0; i < n_exp && i < n_log; i++) begin
         chk(log_k[i] == exp_k[i] && log_w[i] == exp_w[i] &&
             (exp_k[i] == 3 || log_d[i] == exp_d[i]), req,
             (log_k[i] << 16) | (log_w[i] << 8) | log_d[i],
             (exp_k[i] << 16) | (exp_w[i] << 8) | exp_d[i]);
      end
   endtask

   initial begin
      int v;
      void'($urandom(32'd5713));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd1, v); chk(v == 'h11, "R1 status", v, 'h11);
      rd(4'd2, v); chk(v == 0, "R1 irq", v, 0);
      chk(nf_ce_n && nf_we_n && nf_re_n && !irq_o, "R1 pins",
          {nf_ce_n, nf_we_n, nf_re_n, irq_o}, 4'b1110);

      // R12 control readback, width bit set
      wr(4'd0, 16'h0135);
      rd(4'd0, v); chk(v == 'h135, "R12 ctrl readback", v, 'h135);

      // R2 R3 directed: one of each kind with wr delay 5
      clear_logs();
      wr(4'd3, 16'h0090); expect_ent(0, 'h90, 6);
      drain();
      wr(4'd4, 16'h0012); expect_ent(1, 'h12, 6);
      drain();
      wr(4'd5, 16'h00C3); expect_ent(2, 'hC3, 6);
      drain();
      compare_log("R2 R3 R12 kinds");

      // R3 R4 random batches with random write delays
      for (int b = 0; b < 3; b++) begin
         int wdl;
         wdl = int'($urandom_range(0, 7));
         wr(4'd0, 16'(wdl));
         clear_logs();
         for (int j = 0; j < 12; j++) begin
            int k, d;
            k = int'($urandom_range(0, 2));
            d = int'($urandom_range(0, 255));
            do rd(4'd1, v); while (v[1]);
            wr(4'(kind_ofs(k)), 16'(d));
            expect_ent(k, d, strobe_w(k, wdl, 0));
         end
         drain();
         compare_log("R3 R4 random order/width");
      end
      chk(gap_bad == 0, "R3 hold gap", gap_bad, 0);

      // R9 edge bit, R7 write-0 then write-1
      rd(4'd2, v); chk(v[2] == 1, "R9 empty edge", v, 'h4);
      wr(4'd2, 16'h0000);
      rd(4'd2, v); chk(v[2] == 1, "R7 zero write keeps", v, 'h4);
      wr(4'd2, 16'h001F);
      rd(4'd2, v); chk(v == 0, "R7 one write clears", v, 0);
      chk(!irq_o, "R13 irq low", irq_o, 0);

      // R5 overflow with longest write strobe
      wr(4'd0, 16'h0007);
      clear_logs();
      for (int j = 0; j < 6; j++) begin
         wr(4'd5, 16'(8'h40 + j));
         if (j < 5) expect_ent(2, 'h40 + j, 8);
      end
      rd(4'd1, v); chk(v[1] == 1 && v[4] == 0, "R4 full flag", v, 'h2);
      rd(4'd2, v); chk(v[1] == 1, "R5 overflow flag", v, 'h2);
      chk(irq_o, "R13 irq high", irq_o, 1);
      drain();
      compare_log("R5 dropped entry");
      wr(4'd2, 16'h001F);

      // R6 single read, read delay 2
      wr(4'd0, 16'h0020);
      nf_dq_i = 8'hA5;
      clear_logs();
      wr(4'd6, 16'h1234); expect_ent(3, 0, 3);
      drain();
      rd(4'd2, v); chk(v[3] == 1, "R6 read ready", v, 'h8);
      rd(4'd7, v); chk(v == 'hA5, "R6 read data", v, 'hA5);
      compare_log("R6 read strobe");
      wr(4'd2, 16'h001F);

      // R10 page write, small page
      wr(4'd0, 16'h0001);
      wr(4'd8, 16'h0002);
      rd(4'd1, v); chk(v[2] == 1, "R10 write pending", v, 'h4);
      for (int j = 0; j < SMALL - 1; j++) wr(4'd5, 16'(j));
      drain();
      rd(4'd1, v); chk(v[2] == 1, "R10 still pending", v, 'h4);
      wr(4'd5, 16'h00FF);
      drain();
      rd(4'd1, v); chk(v[2] == 0, "R10 pending cleared", v, 0);
      rd(4'd2, v); chk(v[4] == 1, "R10 write done", v, 'h10);
      wr(4'd2, 16'h001F);

      // R11 page read, large page selected
      wr(4'd0, 16'h0211);
      clear_logs();
      nf_dq_i = 8'h30;
      wr(4'd8, 16'h0001);
      rd(4'd1, v); chk(v[3] == 1, "R11 read pending", v, 'h8);
      for (int j = 0; j < LARGE; j++) begin
         do rd(4'd2, v); while (!v[3]);
         rd(4'd7, v); chk(v == 'h30 + j, "R11 page byte", v, 'h30 + j);
         expect_ent(3, 0, 2);
         nf_dq_i = 8'(8'h31 + j);
         if (j == LARGE - 1) begin
            rd(4'd1, v); chk(v[3] == 0, "R11 pending cleared", v, 0);
         end
         wr(4'd2, 16'h0008);
      end
      repeat (8) @(negedge clk);
      compare_log("R11 page reads");

      // R8 ready/busy
      wr(4'd2, 16'h001F);
      nf_rb = 1'b0;
      repeat (4) @(negedge clk);
      rd(4'd1, v); chk(v[0] == 0, "R8 busy level", v, 0);
      rd(4'd2, v); chk(v[0] == 0, "R8 no event on fall", v, 0);
      nf_rb = 1'b1;
      repeat (4) @(negedge clk);
      rd(4'd1, v); chk(v[0] == 1, "R8 ready level", v, 1);
      rd(4'd2, v); chk(v[0] == 1, "R8 ready event", v, 1);

      summary();
      $finish;
   end
endmodule